// File: doc/BRIEF.md
# Two-Dimensional Strided DMA Channel

This block is one DMA channel that generates a sequence of memory addresses in a nested row-and-column pattern. Software programs a small register bank: a start address, an element count per row, a row count, a signed byte stride applied between elements, a signed byte stride applied between rows, and a 16-bit control word. Once enabled, the channel issues one memory request per element on a request/acknowledge port. It keeps each request asserted until the port acknowledges it, then steps the address and the down-counting element and row counters.

Signed strides let the same channel copy a buffer forwards or backwards, or repeatedly hit a fixed peripheral data address (stride zero). Element size is 8, 16 or 32 bits, and the stride is expected to match the size. Completion and a bad-count error are latched in a status register whose bits are cleared by writing one. The level interrupt output is high while either bit is set.

The register map is: 0 start address, 1 element count, 2 row count, 3 element stride, 4 row stride, 5 control word, 6 status, 7 live counters (read only, rows in bits 31:16, elements in bits 15:0). Writes go through a single-cycle write port. Reads come from a separate combinational read port.

Top module: `dma2d_chan`

## Requirements
- R1: After reset no request is issued, `irq` is low, and status (address 6) and live counters (address 7) read zero.
- R2: Control word fields: bit 0 enable, bit 1 direction (driven on `mem_we`), bits 3:2 element size (0 = 8, 1 = 16, 2 = 32 bit, driven on `mem_size`), bit 4 two-dimensional mode, bit 5 restart, bits 7:6 completion-interrupt mode, bits 15:8 stored only. Every field except restart reads back as written.
- R3: A write that takes the enable bit from 0 to 1 (restart clear) starts a job at the start address. In one-dimensional mode the channel issues exactly element-count requests, and the address moves by the sign-extended element stride after each acknowledged element.
- R4: In two-dimensional mode the channel issues element-count requests in each of row-count rows. After the last element of a row that is not the final row, the address moves by the row stride instead of the element stride, and the element counter reloads.
- R5: A negative stride walks addresses downward. A zero stride keeps the address fixed.
- R6: A request stays asserted, and its address unchanged, on every cycle until `mem_ack` is sampled high.
- R7: Address 7 shows the remaining elements in the current row and the remaining rows. Both count down during a job, the row field reads 1 throughout a one-dimensional job, and both read zero after completion.
- R8: If interrupt mode is nonzero, status bit 0 (done) is set in the cycle after the final acknowledge. If it is zero, done is not set.
- R9: Starting with element count zero, or with row count zero in two-dimensional mode, issues no request and sets status bit 1 (error) in the next cycle. Row count is ignored in one-dimensional mode.
- R10: Writing status clears each bit written as 1 and leaves bits written as 0 unchanged.
- R11: `irq` is high exactly while status bit 0 or bit 1 is set.
- R12: Writing the control word with enable 0 stops requests from the next cycle and keeps the counters. A write with restart set also zeroes the counters, stores enable as 0, and never starts a job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DATA_W | Register read data (combinational) |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_addr | output | ADDR_W | Byte address of the current element |
| mem_we | output | 1 | Direction: 1 writes memory |
| mem_size | output | 2 | Element size code |
| mem_ack | input | 1 | Memory acknowledge for the current request |
| irq | output | 1 | Level interrupt: done or error pending |

## Verification
The assertions assume that `mem_ack` is raised only while `mem_req` is high. They also assume that the stride and count registers are not rewritten while a job runs, because the element counter reloads from the live register at each row end. The bench drives the acknowledge from its own model's busy state, with a pseudo-random stall pattern and a long forced stall. It writes job registers only while the channel is idle, except for the deliberate stop and restart writes, which touch only the control word.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [2:0] {
    RA_START = 3'd0,
    RA_XCNT  = 3'd1,
    RA_YCNT  = 3'd2,
    RA_XMOD  = 3'd3,
    RA_YMOD  = 3'd4,
    RA_CFG   = 3'd5,
    RA_STAT  = 3'd6,
    RA_CNT   = 3'd7
  } reg_addr_e;

  // control word, bit 15 first
  typedef struct packed {
    logic [3:0] flow;
    logic [3:0] dsize;
    logic [1:0] imode;
    logic       restart;
    logic       two_d;
    logic [1:0] width;
    logic       wnr;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = 16;
  localparam int STAT_W = 2;

endpackage

// File: rtl/dma2d_regs.sv
module dma2d_regs
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              done_evt,
  input  logic              err_evt,
  input  logic [CNT_W-1:0]  cnt_x,
  input  logic [CNT_W-1:0]  cnt_y,
  output logic [ADDR_W-1:0] start_addr,
  output logic [CNT_W-1:0]  x_cnt,
  output logic [CNT_W-1:0]  y_cnt,
  output logic [CNT_W-1:0]  x_mod,
  output logic [CNT_W-1:0]  y_mod,
  output logic              start_evt,
  output logic              start_2d,
  output logic              stop_evt,
  output logic              clear_evt,
  output logic              cfg_wnr,
  output logic [1:0]        cfg_width,
  output logic              irq_on,
  output logic [STAT_W-1:0] stat
);

  logic [ADDR_W-1:0] start_q, start_d;
  logic [CNT_W-1:0]  xc_q, xc_d, yc_q, yc_d, xm_q, xm_d, ym_q, ym_d;
  ctrl_t             cfg_q, cfg_d, new_cfg;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic              cfg_wr;

  always_comb begin
    start_d = start_q;
    xc_d    = xc_q;
    yc_d    = yc_q;
    xm_d    = xm_q;
    ym_d    = ym_q;
    cfg_d   = cfg_q;
    stat_d  = stat_q;
    new_cfg = ctrl_t'(wr_data[CTRL_W-1:0]);
    cfg_wr  = wr_en && (wr_addr == RA_CFG);
    if (wr_en) begin
      case (reg_addr_e'(wr_addr))
        RA_START: start_d = wr_data[ADDR_W-1:0];
        RA_XCNT:  xc_d    = wr_data[CNT_W-1:0];
        RA_YCNT:  yc_d    = wr_data[CNT_W-1:0];
        RA_XMOD:  xm_d    = wr_data[CNT_W-1:0];
        RA_YMOD:  ym_d    = wr_data[CNT_W-1:0];
        RA_CFG: begin
          cfg_d         = new_cfg;
          cfg_d.en      = new_cfg.en & ~new_cfg.restart;
          cfg_d.restart = 1'b0;
        end
        RA_STAT:  stat_d  = stat_q & ~wr_data[STAT_W-1:0];
        default: ;
      endcase
    end
    stat_d = stat_d | {err_evt, done_evt};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      xc_q    <= '0;
      yc_q    <= '0;
      xm_q    <= '0;
      ym_q    <= '0;
      cfg_q   <= '0;
      stat_q  <= '0;
    end else begin
      start_q <= start_d;
      xc_q    <= xc_d;
      yc_q    <= yc_d;
      xm_q    <= xm_d;
      ym_q    <= ym_d;
      cfg_q   <= cfg_d;
      stat_q  <= stat_d;
    end
  end

  assign start_evt = cfg_wr && new_cfg.en && !cfg_q.en && !new_cfg.restart;
  assign start_2d  = new_cfg.two_d;
  assign stop_evt  = cfg_wr && (!new_cfg.en || new_cfg.restart);
  assign clear_evt = cfg_wr && new_cfg.restart;

  assign start_addr = start_q;
  assign x_cnt      = xc_q;
  assign y_cnt      = yc_q;
  assign x_mod      = xm_q;
  assign y_mod      = ym_q;
  assign cfg_wnr    = cfg_q.wnr;
  assign cfg_width  = cfg_q.width;
  assign irq_on     = |cfg_q.imode;
  assign stat       = stat_q;

  always_comb begin
    case (reg_addr_e'(rd_addr))
      RA_START: rd_data = DATA_W'(start_q);
      RA_XCNT:  rd_data = DATA_W'(xc_q);
      RA_YCNT:  rd_data = DATA_W'(yc_q);
      RA_XMOD:  rd_data = DATA_W'(xm_q);
      RA_YMOD:  rd_data = DATA_W'(ym_q);
      RA_CFG:   rd_data = DATA_W'(cfg_q);
      RA_STAT:  rd_data = DATA_W'(stat_q);
      default:  rd_data = DATA_W'({cnt_y, cnt_x});
    endcase
  end

endmodule

// File: rtl/dma2d_seq.sv
module dma2d_seq #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              start_2d,
  input  logic              stop_evt,
  input  logic              clear_evt,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  x_cnt,
  input  logic [CNT_W-1:0]  y_cnt,
  input  logic [CNT_W-1:0]  x_mod,
  input  logic [CNT_W-1:0]  y_mod,
  input  logic              irq_on,
  input  logic              mem_ack,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cnt_x,
  output logic [CNT_W-1:0]  cnt_y,
  output logic              done_evt,
  output logic              err_evt
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] addr_q, addr_d, x_step, y_step;
  logic [CNT_W-1:0]  cx_q, cx_d, cy_q, cy_d;
  logic              bad_cnt;

  assign x_step  = ADDR_W'($signed(x_mod));
  assign y_step  = ADDR_W'($signed(y_mod));
  assign bad_cnt = (x_cnt == '0) || (start_2d && (y_cnt == '0));

  always_comb begin
    busy_d   = busy_q;
    addr_d   = addr_q;
    cx_d     = cx_q;
    cy_d     = cy_q;
    done_evt = 1'b0;
    err_evt  = 1'b0;
    if (clear_evt) begin
      busy_d = 1'b0;
      cx_d   = '0;
      cy_d   = '0;
    end else if (stop_evt) begin
      busy_d = 1'b0;
    end else if (start_evt) begin
      if (bad_cnt) begin
        err_evt = 1'b1;
      end else begin
        busy_d = 1'b1;
        addr_d = start_addr;
        cx_d   = x_cnt;
        cy_d   = start_2d ? y_cnt : ONE;
      end
    end else if (busy_q && mem_ack) begin
      if (cx_q != ONE) begin
        cx_d   = cx_q - ONE;
        addr_d = addr_q + x_step;
      end else if (cy_q != ONE) begin
        cx_d   = x_cnt;
        cy_d   = cy_q - ONE;
        addr_d = addr_q + y_step;
      end else begin
        busy_d   = 1'b0;
        cx_d     = '0;
        cy_d     = '0;
        done_evt = irq_on;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      addr_q <= '0;
      cx_q   <= '0;
      cy_q   <= '0;
    end else begin
      busy_q <= busy_d;
      addr_q <= addr_d;
      cx_q   <= cx_d;
      cy_q   <= cy_d;
    end
  end

  assign busy     = busy_q;
  assign cur_addr = addr_q;
  assign cnt_x    = cx_q;
  assign cnt_y    = cy_q;

endmodule

// File: rtl/dma2d_chan.sv
module dma2d_chan
  import dma2d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  input  logic              mem_ack,
  output logic              irq
);

  logic [ADDR_W-1:0] start_addr;
  logic [CNT_W-1:0]  x_cnt, y_cnt, x_mod, y_mod, cnt_x, cnt_y;
  logic              start_evt, start_2d, stop_evt, clear_evt, irq_on;
  logic              done_evt, err_evt, busy;
  logic [STAT_W-1:0] stat;

  dma2d_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .done_evt(done_evt), .err_evt(err_evt),
    .cnt_x(cnt_x), .cnt_y(cnt_y),
    .start_addr(start_addr), .x_cnt(x_cnt), .y_cnt(y_cnt),
    .x_mod(x_mod), .y_mod(y_mod),
    .start_evt(start_evt), .start_2d(start_2d),
    .stop_evt(stop_evt), .clear_evt(clear_evt),
    .cfg_wnr(mem_we), .cfg_width(mem_size), .irq_on(irq_on),
    .stat(stat)
  );

  dma2d_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_evt(start_evt), .start_2d(start_2d),
    .stop_evt(stop_evt), .clear_evt(clear_evt),
    .start_addr(start_addr), .x_cnt(x_cnt), .y_cnt(y_cnt),
    .x_mod(x_mod), .y_mod(y_mod), .irq_on(irq_on),
    .mem_ack(mem_ack),
    .busy(busy), .cur_addr(mem_addr),
    .cnt_x(cnt_x), .cnt_y(cnt_y),
    .done_evt(done_evt), .err_evt(err_evt)
  );

  assign mem_req = busy;
  assign irq     = |stat;

endmodule

// File: rtl/dma2d_chan_chk.sv
module dma2d_chan_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy,
  input logic              stop_evt,
  input logic [CNT_W-1:0]  cnt_x,
  input logic [CNT_W-1:0]  cnt_y,
  input logic [1:0]        stat
);

  // R6: an unacknowledged request persists with the same address
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !wr_en |=> mem_req && $stable(mem_addr));

  // R7: counters move only on an acknowledge
  a_r7_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !wr_en |=> $stable(cnt_x) && $stable(cnt_y));

  // R7: a running job never shows an exhausted counter
  a_r7_cnt_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_x != '0) && (cnt_y != '0));

  // R8: done rises only right after an acknowledged element
  a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[0]) |-> $past(mem_ack && busy));

  // R9: an error is flagged with no job running
  a_r9_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[1]) |-> !busy);

  // R12: a stopping control write drops the request next cycle
  a_r12_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !mem_req);

endmodule

bind dma2d_chan dma2d_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_dma2d_chan.sv
`timescale 1ns/1ps
module tb_dma2d_chan;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_we;
  logic [1:0]  mem_size;
  logic        mem_ack;
  logic        irq;

  dma2d_chan dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_size(mem_size), .mem_ack(mem_ack), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;
  int cyc = 0;
  int rd_sel = -1;
  bit stall = 0;
  logic [7:0] lfsr = 8'h5A;

  // reference model state
  logic [31:0] m_start;
  logic [15:0] m_xc, m_yc, m_xm, m_ym, m_cfg, m_cx, m_cy;
  logic [1:0]  m_stat;
  logic        m_busy;
  logic [31:0] m_addr, last_addr;
  int          n_acks;

  function automatic logic [31:0] sext(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic [15:0] nc;
    logic cw, st, sp, cl, dn, er;
    if (!rst_n) begin
      m_start = 0; m_xc = 0; m_yc = 0; m_xm = 0; m_ym = 0; m_cfg = 0;
      m_stat = 0; m_busy = 0; m_addr = 0; m_cx = 0; m_cy = 0;
    end else begin
      nc = wr_data[15:0];
      cw = wr_en && (wr_addr == 3'd5);
      st = cw && nc[0] && !m_cfg[0] && !nc[5];
      sp = cw && (!nc[0] || nc[5]);
      cl = cw && nc[5];
      dn = 0; er = 0;
      if (cl) begin
        m_busy = 0; m_cx = 0; m_cy = 0;
      end else if (sp) begin
        m_busy = 0;
      end else if (st) begin
        if (m_xc == 0 || (nc[4] && m_yc == 0)) er = 1;
        else begin
          m_busy = 1; m_addr = m_start; m_cx = m_xc;
          m_cy = nc[4] ? m_yc : 16'd1;
        end
      end else if (m_busy && mem_ack) begin
        n_acks++;
        last_addr = m_addr;
        if (m_cx > 1) begin
          m_cx--; m_addr = m_addr + sext(m_xm);
        end else if (m_cy > 1) begin
          m_cx = m_xc; m_cy--; m_addr = m_addr + sext(m_ym);
        end else begin
          m_busy = 0; m_cx = 0; m_cy = 0; dn = (m_cfg[7:6] != 0);
        end
      end
      if (wr_en && wr_addr == 3'd6) m_stat = m_stat & ~wr_data[1:0];
      if (dn) m_stat[0] = 1;
      if (er) m_stat[1] = 1;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_start = wr_data;
          3'd1: m_xc = wr_data[15:0];
          3'd2: m_yc = wr_data[15:0];
          3'd3: m_xm = wr_data[15:0];
          3'd4: m_ym = wr_data[15:0];
          3'd5: begin m_cfg = nc; m_cfg[5] = 0; if (nc[5]) m_cfg[0] = 0; end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_start;
      3'd1: return {16'd0, m_xc};
      3'd2: return {16'd0, m_yc};
      3'd3: return {16'd0, m_xm};
      3'd4: return {16'd0, m_ym};
      3'd5: return {16'd0, m_cfg};
      3'd6: return {30'd0, m_stat};
      default: return {m_cy, m_cx};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R6 request vs model", {31'd0, mem_req}, {31'd0, m_busy});
    if (m_busy) begin
      chk("R3 address vs model", mem_addr, m_addr);
      chk("R2 direction", {31'd0, mem_we}, {31'd0, m_cfg[1]});
      chk("R2 size", {30'd0, mem_size}, {30'd0, m_cfg[3:2]});
    end
    chk("R11 irq", {31'd0, irq}, {31'd0, (|m_stat)});
    case (rd_addr)
      3'd7: chk("R7 live counters", rd_data, exp_rd(rd_addr));
      3'd6: chk("R10 status", rd_data, exp_rd(rd_addr));
      3'd5: chk("R2 control readback", rd_data, exp_rd(rd_addr));
      default: chk("R3 register readback", rd_data, exp_rd(rd_addr));
    endcase
  endtask

  task automatic step(input logic we, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    compare_all();
    cyc++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wr_en = we; wr_addr = a; wr_data = d;
    rd_addr = (rd_sel >= 0) ? rd_sel[2:0] : cyc[2:0];
    mem_ack = m_busy && !stall && (lfsr[1:0] != 2'b00);
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string tag);
    rd_sel = a;
    step(0, 0, 0);
    #1;
    chk(tag, rd_data, exp);
    rd_sel = -1;
  endtask

  task automatic setup(input logic [31:0] sa, input int xc, input int yc,
                       input int xm, input int ym);
    step(1, 5, 0);
    step(1, 0, sa);
    step(1, 1, 32'(xc & 16'hFFFF));
    step(1, 2, 32'(yc & 16'hFFFF));
    step(1, 3, 32'(xm & 16'hFFFF));
    step(1, 4, 32'(ym & 16'hFFFF));
    n_acks = 0;
  endtask

  task automatic finish_job(input string tag);
    step(0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      if (!m_busy) break;
      step(0, 0, 0);
    end
    if (m_busy) chk({tag, " job timeout"}, 1, 0);
    step(0, 0, 0);
  endtask

  task automatic job(input logic [31:0] sa, input int xc, input int yc, input int xm,
                     input int ym, input logic [15:0] cfg, input string tag);
    setup(sa, xc, yc, xm, ym);
    step(1, 5, {16'd0, cfg});
    finish_job(tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; mem_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk("R1 no request after reset", {31'd0, mem_req}, 0);
    chk("R1 irq low after reset", {31'd0, irq}, 0);
    rd_check(6, 0, "R1 status zero");
    rd_check(7, 0, "R1 counters zero");

    // R2 stored fields read back while disabled
    step(1, 5, 32'h0000_A2C0);
    rd_check(5, 32'h0000_A2C0, "R2 control fields stored");

    // R3 / R8: 1D, 16-bit, incrementing, interrupt mode 2
    job(32'h1000, 5, 0, 2, 0, 16'h0085, "R3");
    chk("R3 element count", n_acks, 5);
    chk("R3 last address", last_addr, 32'h1008);
    rd_check(6, 1, "R8 done set");
    step(1, 6, 2);
    rd_check(6, 1, "R10 zero bit leaves done");
    step(1, 6, 1);
    rd_check(6, 0, "R10 one clears done");

    // R4: 2D, 8-bit, write direction
    job(32'h2000, 4, 3, 1, 13, 16'h0053, "R4");
    chk("R4 element count", n_acks, 12);
    chk("R4 last address", last_addr, 32'h2023);
    step(1, 6, 3);

    // R5: 2D, 32-bit, downward
    job(32'h3100, 3, 2, -4, -4, 16'h00D9, "R5");
    chk("R5 element count", n_acks, 6);
    chk("R5 last address downward", last_addr, 32'h30EC);
    step(1, 6, 3);

    // R5 / R8: fixed address, interrupt mode 0
    job(32'h4444, 6, 0, 0, 0, 16'h0001, "R5");
    chk("R5 fixed address count", n_acks, 6);
    chk("R5 fixed address", last_addr, 32'h4444);
    rd_check(6, 0, "R8 no done with interrupt off");

    // R9 / R11: zero element count
    job(32'h5000, 0, 4, 1, 1, 16'h0081, "R9");
    chk("R9 no requests", n_acks, 0);
    rd_check(6, 2, "R9 error set");
    chk("R11 irq on error", {31'd0, irq}, 1);
    step(1, 6, 2);
    rd_check(6, 0, "R10 error cleared");

    // R9: zero rows in 2D, ignored in 1D
    job(32'h5000, 3, 0, 1, 1, 16'h0091, "R9");
    chk("R9 2D zero rows no requests", n_acks, 0);
    rd_check(6, 2, "R9 2D zero rows error");
    step(1, 6, 2);
    job(32'h5100, 2, 0, 1, 1, 16'h0081, "R9");
    chk("R9 1D ignores rows", n_acks, 2);
    rd_check(6, 1, "R9 1D completes with done");
    step(1, 6, 3);

    // R6: long stall holds the request
    setup(32'h6000, 8, 0, 4, 0);
    stall = 1;
    step(1, 5, 32'h0089);
    step(0, 0, 0);
    held = mem_addr;
    repeat (10) step(0, 0, 0);
    chk("R6 request held", {31'd0, mem_req}, 1);
    chk("R6 address held", mem_addr, held);
    chk("R6 no progress while stalled", n_acks, 0);
    stall = 0;
    finish_job("R6");
    chk("R6 element count", n_acks, 8);
    step(1, 6, 3);

    // R12: stop, restart, enable with restart
    setup(32'h7000, 40, 0, 4, 0);
    step(1, 5, 32'h0089);
    repeat (12) step(0, 0, 0);
    step(1, 5, 32'h0088);
    repeat (3) step(0, 0, 0);
    chk("R12 stopped", {31'd0, mem_req}, 0);
    rd_check(7, {m_cy, m_cx}, "R12 counters kept");
    chk("R12 paused count nonzero", {31'd0, (rd_data[15:0] != 0)}, 1);
    step(1, 5, 32'h0020);
    rd_check(7, 0, "R12 restart zeroes counters");
    step(1, 5, 32'h0021);
    repeat (3) step(0, 0, 0);
    chk("R12 restart blocks start", {31'd0, mem_req}, 0);
    rd_check(5, 0, "R12 enable stored as zero");
    n_acks = 0;
    step(1, 5, 32'h0089);
    finish_job("R12");
    chk("R12 fresh job count", n_acks, 40);
    chk("R12 fresh job last address", last_addr, 32'h7000 + 39 * 4);

    repeat (4) step(0, 0, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule